// File: doc/BRIEF.md
# Fault-Injectable Majority Voter

This block is a three-input majority gate that can be switched, through two control inputs, into one of two logical fault models. It lets a gate-level model of a majority-gate fabric carry the logic-level effect of cell-deposition defects, so that test patterns and fault effects can be studied without a physical simulation. With both controls low the gate returns the majority of its three data inputs. One control setting makes the output copy the middle input (a stuck-at-B fault). Another makes the gate vote on the first and third inputs inverted.

The block is purely combinational. It has no clock, no reset and no storage. The data inputs are vectors of `WIDTH` independent lanes, and all lanes share one fault code. This lets a single instance stand for a row of identical voters that share one fault setting. The output settles in the same evaluation as the inputs.

Top module: `fault_inj_majority`

## Requirements
- R1: With mode_hi=0 and mode_lo=0 (fault-free), each lane of vote_out is 1 exactly when at least two of the lane's vote_a, vote_b and vote_c bits are 1.
- R2: With mode_hi=0 and mode_lo=1 (stuck-at-B), each lane of vote_out equals that lane's vote_b bit, whatever vote_a and vote_c hold.
- R3: With mode_hi=1 and mode_lo=0 (inverted-outer fault), each lane of vote_out is the majority of the inverted vote_a bit, the vote_b bit and the inverted vote_c bit.
- R4: The spare code mode_hi=1 and mode_lo=1 gives the same output as the fault-free code.
- R5: Each lane's output depends only on that lane's three data bits and the shared fault code. The output follows the inputs with no clock and no stored state.
- R6: Under stuck-at-B, a lane's output differs from its fault-free output only for the lane inputs (a,b,c) = 010 and 101.
- R7: For lane inputs a=0, b=1, c=0, the output is 0 under the fault-free code and 1 under stuck-at-B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vote_a | input | WIDTH | First data input of each lane |
| vote_b | input | WIDTH | Middle data input of each lane; copied to the output under stuck-at-B |
| vote_c | input | WIDTH | Third data input of each lane |
| mode_hi | input | 1 | Upper fault-select bit; with mode_lo low it selects the inverted-outer fault |
| mode_lo | input | 1 | Lower fault-select bit; with mode_hi low it selects stuck-at-B |
| vote_out | output | WIDTH | Per-lane voter result |

## Verification
The bench builds the block with WIDTH=3. Each lane then receives a different rotation of the eight-pattern input table in the same vector. A single sweep of eight vectors under each of the four fault codes therefore covers every input pattern on every lane, and it would expose any leakage between lanes or any lane that decodes the mode differently. The directed cases then isolate the single differing patterns of the stuck-at-B fault and the spare code.

// File: rtl/fimv_pkg.sv
package fimv_pkg;

  typedef enum logic [1:0] {
    MODE_CLEAN   = 2'd0,
    MODE_STUCK_B = 2'd1,
    MODE_INV_AC  = 2'd2
  } fimv_mode_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction

endpackage

// File: rtl/fimv_mode_decode.sv
module fimv_mode_decode
  import fimv_pkg::*;
(
  input  logic       mode_hi,
  input  logic       mode_lo,
  output fimv_mode_e mode
);

  always_comb begin
    unique case ({mode_hi, mode_lo})
      2'b01:   mode = MODE_STUCK_B;
      2'b10:   mode = MODE_INV_AC;
      default: mode = MODE_CLEAN;  // 00 and the spare 11
    endcase
  end

  // R4
  always_comb begin
    if (mode_hi && mode_lo) begin
      spare_code_clean_chk: assert (mode == MODE_CLEAN);
    end
  end

endmodule

// File: rtl/fimv_lane.sv
module fimv_lane
  import fimv_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       c,
  input  fimv_mode_e mode,
  output logic       y
);

  logic flip_outer;
  logic a_eff;
  logic c_eff;
  logic voted;

  always_comb begin
    flip_outer = (mode == MODE_INV_AC);
    a_eff      = a ^ flip_outer;
    c_eff      = c ^ flip_outer;
    voted      = maj3(a_eff, b, c_eff);
    y          = (mode == MODE_STUCK_B) ? b : voted;
  end

endmodule

// File: rtl/fault_inj_majority.sv
module fault_inj_majority
  import fimv_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic [WIDTH-1:0] vote_a,
  input  logic [WIDTH-1:0] vote_b,
  input  logic [WIDTH-1:0] vote_c,
  input  logic             mode_hi,
  input  logic             mode_lo,
  output logic [WIDTH-1:0] vote_out
);

  fimv_mode_e mode_q;

  fimv_mode_decode u_dec (
    .mode_hi (mode_hi),
    .mode_lo (mode_lo),
    .mode    (mode_q)
  );

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    fimv_lane u_lane (
      .a    (vote_a[g]),
      .b    (vote_b[g]),
      .c    (vote_c[g]),
      .mode (mode_q),
      .y    (vote_out[g])
    );

    logic [2:0] abc;
    logic       ones_ge2;
    logic       inv_ge2;
    always_comb begin
      abc      = {vote_a[g], vote_b[g], vote_c[g]};
      ones_ge2 = ($countones(abc) >= 2);
      inv_ge2  = ($countones(abc ^ 3'b101) >= 2);
    end

    // R1
    always_comb begin
      if (!mode_hi && !mode_lo) begin
        clean_vote_chk: assert (vote_out[g] == ones_ge2);
      end
    end

    // R2
    always_comb begin
      if (!mode_hi && mode_lo) begin
        stuck_b_chk: assert (vote_out[g] == vote_b[g]);
      end
    end

    // R3
    always_comb begin
      if (mode_hi && !mode_lo) begin
        inv_outer_chk: assert (vote_out[g] == inv_ge2);
      end
    end

    // R4
    always_comb begin
      if (mode_hi && mode_lo) begin
        spare_as_clean_chk: assert (vote_out[g] == ones_ge2);
      end
    end

    // R6
    always_comb begin
      if (!mode_hi && mode_lo && abc != 3'b010 && abc != 3'b101) begin
        stuck_b_agree_chk: assert (vote_out[g] == ones_ge2);
      end
    end
  end

endmodule

// File: tb/tb_fault_inj_majority.sv
module tb_fault_inj_majority;

  localparam int W = 3;

  // Expected output per input pattern {a,b,c}; bit index = {mode_hi,mode_lo}
  // bit0 clean (R1), bit1 stuck-at-B (R2), bit2 inverted outer (R3), bit3 spare (R4)
  localparam logic [3:0] EXP_TBL [8] = '{
    4'b0100,  // 000
    4'b0000,  // 001
    4'b0110,  // 010
    4'b1111,  // 011
    4'b0000,  // 100
    4'b1001,  // 101
    4'b1111,  // 110
    4'b1011   // 111
  };

  logic clk;
  logic [W-1:0] va, vb, vc;
  logic mhi, mlo;
  logic [W-1:0] vout;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  fault_inj_majority #(.WIDTH(W)) dut (
    .vote_a   (va),
    .vote_b   (vb),
    .vote_c   (vc),
    .mode_hi  (mhi),
    .mode_lo  (mlo),
    .vote_out (vout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                       input logic hi, input logic lo);
    @(posedge clk);
    va = a; vb = b; vc = c; mhi = hi; mlo = lo;
    @(negedge clk);
  endtask

  initial begin
    va = '0; vb = '0; vc = '0; mhi = 1'b0; mlo = 1'b0;
    @(negedge clk);
    // R1: all-zero inputs, fault-free, give zero on every lane
    check("R1 idle", vout, '0);

    // Table sweep: every mode, every pattern, lanes rotated (R1 R2 R3 R4 R5)
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 8; i++) begin
        logic [W-1:0] a, b, c, e;
        for (int k = 0; k < W; k++) begin
          int p;
          p = (i + k) % 8;
          a[k] = p[2]; b[k] = p[1]; c[k] = p[0];
          e[k] = EXP_TBL[p][m];
        end
        apply(a, b, c, m[1], m[0]);
        case (m)
          0: check("R1 sweep", vout, e);
          1: check("R2 sweep", vout, e);
          2: check("R3 sweep", vout, e);
          default: check("R4 sweep", vout, e);
        endcase
      end
    end

    // R7: the worked example on all lanes
    apply('0, '1, '0, 1'b0, 1'b0);
    check("R7 clean 010", vout, '0);
    apply('0, '1, '0, 1'b0, 1'b1);
    check("R7 stuck 010", vout, '1);

    // R6: stuck-at-B differs from clean only at 010 and 101
    for (int p = 0; p < 8; p++) begin
      logic [W-1:0] ref_clean, ref_stuck, got_clean, got_stuck;
      logic [2:0] pv;
      pv = p[2:0];
      apply({W{pv[2]}}, {W{pv[1]}}, {W{pv[0]}}, 1'b0, 1'b0);
      got_clean = vout;
      apply({W{pv[2]}}, {W{pv[1]}}, {W{pv[0]}}, 1'b0, 1'b1);
      got_stuck = vout;
      ref_clean = (got_clean ^ got_stuck);
      ref_stuck = (pv == 3'b010 || pv == 3'b101) ? '1 : '0;
      check("R6 difference", ref_clean, ref_stuck);
    end

    // R5: change inputs only (no clock edge in between) and see the output follow
    @(posedge clk);
    va = 3'b110; vb = 3'b101; vc = 3'b011; mhi = 1'b0; mlo = 1'b0;
    #1;
    check("R5 same-step", vout, 3'b111);
    vb = 3'b000;
    #1;
    check("R5 lane-isolation", vout, 3'b010);

    // R4 vs R1 on a mixed vector
    apply(3'b100, 3'b110, 3'b011, 1'b1, 1'b1);
    check("R4 spare mixed", vout, 3'b110);
    // R3 on a mixed vector: lanes (a,b,c) = 2:(1,1,0) 1:(0,1,1) 0:(0,0,1)
    apply(3'b100, 3'b110, 3'b011, 1'b1, 1'b0);
    check("R3 mixed", vout, 3'b110);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule